// File: doc/BRIEF.md
# Seconds Real-Time Clock with Drift Correction and Alarms

The block keeps a 32-bit count of seconds, advanced by strobes from a nominal 32768 Hz oscillator that arrive as one-cycle pulses on `osc_tick`. A signed correction setting makes some seconds one oscillator cycle longer or shorter, so that a crystal that runs fast or slow averages out to the right rate. Two alarm channels compare the time with programmed values. Each channel can also raise a periodic event. Its status bit and a shared level interrupt report the events.

Software reaches the block through a simple word-wide register port. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. After reset the clock is held stopped until the configuration byte is written to zero. Writes that target unaligned or unknown addresses have no effect, and reads from them return zero.

The second counter is a four-state machine. ST_HALT holds the counter while the configuration byte is non-zero, and it is left for ST_NOMINAL once the byte is zero. In ST_NOMINAL a second lasts TICKS_PER_SEC oscillator cycles, in ST_STRETCH it lasts one cycle more, and in ST_SHRINK one cycle fewer. At the end of every second the correction accumulator picks the length of the next second. It moves to ST_STRETCH when the accumulated error reaches +1 cycle, to ST_SHRINK when it reaches -1 cycle, and to ST_NOMINAL otherwise. Writing the time returns the machine to ST_NOMINAL from any running state. Writing a non-zero configuration byte returns it to ST_HALT from any state.

Top module: `rtc_core`

## Requirements
- R1: After reset the registers read as follows: time 0, status 0, both interrupt configurations 0, both compare values 0, correction 0x00002000 and configuration 0x000000A5. `irq` is low.
- R2: While bits 7:0 of the configuration register (0x1C) are non-zero, the time does not advance. Once they are written to 0, the time increments on the TICKS_PER_SEC-th following `osc_tick`.
- R3: A write to the time register (0x0C) loads the value and restarts the current second from zero. The time counts up by one per second and wraps from 0xFFFFFFFF to 0.
- R4: The register widths are as follows. The compare registers 0x10 and 0x14 hold 32 bits. The interrupt configurations 0x04 and 0x08 hold bits 2:0. The correction register 0x18 holds bits 15:0. The configuration register 0x1C holds bits 7:0. Bits that are not held read as zero.
- R5: For alarm n (n=0 uses 0x04 and 0x10, n=1 uses 0x08 and 0x14), status bit n (register 0x00) is set when the time advances to a value equal to the compare value while bit 0 of the configuration is 1. The bit is not set while bit 0 is 0.
- R6: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R7: `irq` is high exactly when some status bit n is 1 and bit 0 or bit 1 of configuration n is 1.
- R8: If bit 1 of configuration n is 1, status bit n is set at every second boundary. If bit 2 is 0 as well, the bit is also set on the (TICKS_PER_SEC/2)-th tick of each second.
- R9: The correction register holds a two's-complement offset in bits 7:0. Each second adds offset×step ppb to an accumulator. When the total reaches 1e9/TICKS_PER_SEC, the next second is one tick longer and that amount is removed from the total. Writing the correction register or the time register clears the accumulator.
- R10: When the total falls to -1e9/TICKS_PER_SEC or below, the next second is one tick shorter and that amount is added back.
- R11: Bit 15 of the correction register selects the step: 954 ppb when it is 0, 3815 ppb when it is 1.
- R12: The correction applies only when bits 14:8 equal {0, ~S, S, S, S, S, S}, where S is bit 7. Any other pattern gives zero correction, so 0x2000 means nominal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt |

## Verification
A wrong second-machine state or a wrong accumulator value shows at the ports as a time value that is one second early or late. It becomes visible at the first boundary where a stretched or shrunk second should or should not occur, which can be more than a hundred seconds after the correction write. For this reason, reads are placed on the tick just before and just after each predicted slip. A status bit that is set or cleared wrongly shows on `irq` and on the status read in the very next cycle. The checks after each event are placed there.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ALARMS = 2;
    localparam int AW     = 5;

    typedef enum logic [1:0] {
        ST_HALT,
        ST_NOMINAL,
        ST_STRETCH,
        ST_SHRINK
    } sec_state_e;

    typedef struct packed {
        logic rate_1hz;
        logic per_en;
        logic al_en;
    } irq_cfg_t;

    localparam logic [AW-1:0] A_STATUS = 5'h00;
    localparam logic [AW-1:0] A_CFG0   = 5'h04;
    localparam logic [AW-1:0] A_TIME   = 5'h0C;
    localparam logic [AW-1:0] A_CMP0   = 5'h10;
    localparam logic [AW-1:0] A_CORR   = 5'h18;
    localparam logic [AW-1:0] A_TEST   = 5'h1C;

    localparam logic [15:0] CORR_RESET = 16'h2000;
    localparam logic [7:0]  TEST_RESET = 8'hA5;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [31:0]                bus_wdata,
    input  logic [31:0]                time_q,
    input  logic [ALARMS-1:0]          status_q,
    output irq_cfg_t [ALARMS-1:0]      cfg_q,
    output logic [ALARMS-1:0][31:0]    cmp_q,
    output logic [15:0]                corr_q,
    output logic [7:0]                 test_q,
    output logic                       time_wr,
    output logic                       corr_wr,
    output logic [ALARMS-1:0]          stat_clr,
    output logic [31:0]                bus_rdata
);
    logic test_wr;

    assign time_wr = bus_wr && (bus_addr == A_TIME);
    assign corr_wr = bus_wr && (bus_addr == A_CORR);
    assign test_wr = bus_wr && (bus_addr == A_TEST);
    assign stat_clr = (bus_wr && (bus_addr == A_STATUS)) ? bus_wdata[ALARMS-1:0]
                                                         : '0;

    for (genvar i = 0; i < ALARMS; i++) begin : g_chan
        localparam logic [AW-1:0] CFG_A = A_CFG0 + AW'(4 * i);
        localparam logic [AW-1:0] CMP_A = A_CMP0 + AW'(4 * i);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
                cmp_q[i] <= '0;
            end else if (bus_wr) begin
                if (bus_addr == CFG_A) cfg_q[i] <= irq_cfg_t'(bus_wdata[2:0]);
                if (bus_addr == CMP_A) cmp_q[i] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_q <= CORR_RESET;
            test_q <= TEST_RESET;
        end else begin
            if (corr_wr) corr_q <= bus_wdata[15:0];
            if (test_wr) test_q <= bus_wdata[7:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STATUS) bus_rdata = 32'(status_q);
        if (bus_addr == A_TIME)   bus_rdata = time_q;
        if (bus_addr == A_CORR)   bus_rdata = 32'(corr_q);
        if (bus_addr == A_TEST)   bus_rdata = 32'(test_q);
        for (int i = 0; i < ALARMS; i++) begin
            if (bus_addr == A_CFG0 + AW'(4 * i)) bus_rdata = 32'(cfg_q[i]);
            if (bus_addr == A_CMP0 + AW'(4 * i)) bus_rdata = cmp_q[i];
        end
    end
endmodule

// File: rtl/rtc_sec_fsm.sv
module rtc_sec_fsm
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int FINE_PPB      = 954,
    parameter int COARSE_PPB    = 3815
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick,
    input  logic        run,
    input  logic        restart,
    input  logic        corr_clr,
    input  logic [15:0] corr,
    output logic        sec_evt,
    output logic        half_evt,
    output logic        counting
);
    localparam int CNT_W = $clog2(TICKS_PER_SEC + 1);
    localparam int HALF  = TICKS_PER_SEC / 2;
    localparam logic signed [31:0] THR = 32'(1_000_000_000 / TICKS_PER_SEC);

    sec_state_e state_q, state_d, verdict;
    logic [CNT_W-1:0] cnt_q, last_idx;
    logic signed [31:0] acc_q, acc_sum, acc_left, delta, off_ext, step;
    logic sign_b, pat_ok, end_hit;

    // correction decode: offset times selected step, zero on a bad pattern
    always_comb begin
        sign_b  = corr[7];
        pat_ok  = (corr[14:8] == {1'b0, ~sign_b, {5{sign_b}}});
        off_ext = 32'(signed'(corr[7:0]));
        step    = corr[15] ? 32'(COARSE_PPB) : 32'(FINE_PPB);
        delta   = pat_ok ? off_ext * step : '0;
        acc_sum = acc_q + delta;
        if (acc_sum >= THR) begin
            verdict  = ST_STRETCH;
            acc_left = acc_sum - THR;
        end else if (acc_sum <= -THR) begin
            verdict  = ST_SHRINK;
            acc_left = acc_sum + THR;
        end else begin
            verdict  = ST_NOMINAL;
            acc_left = acc_sum;
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_HALT:    last_idx = '0;
            ST_NOMINAL: last_idx = CNT_W'(TICKS_PER_SEC - 1);
            ST_STRETCH: last_idx = CNT_W'(TICKS_PER_SEC);
            ST_SHRINK:  last_idx = CNT_W'(TICKS_PER_SEC - 2);
        endcase
        counting = (state_q != ST_HALT);
        end_hit  = counting && osc_tick && (cnt_q == last_idx);
        sec_evt  = end_hit && run && !restart;
        half_evt = counting && osc_tick && (cnt_q == CNT_W'(HALF - 1))
                   && run && !restart;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:                            if (run) state_d = ST_NOMINAL;
            ST_NOMINAL, ST_STRETCH, ST_SHRINK:  if (end_hit) state_d = verdict;
        endcase
        if (!run)         state_d = ST_HALT;
        else if (restart) state_d = ST_NOMINAL;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // tick counter and error accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else begin
            if (!run || restart || !counting) cnt_q <= '0;
            else if (osc_tick)                cnt_q <= end_hit ? '0 : cnt_q + 1'b1;

            if (!run || restart || !counting || corr_clr) acc_q <= '0;
            else if (end_hit)                             acc_q <= acc_left;
        end
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_evt,
    input  logic        half_evt,
    input  logic [31:0] time_next,
    input  logic [31:0] cmp,
    input  irq_cfg_t    cfg,
    input  logic        clr,
    output logic        status,
    output logic        irq_req
);
    logic hit_alarm, hit_period, set;

    always_comb begin
        hit_alarm  = cfg.al_en && sec_evt && (time_next == cmp);
        hit_period = cfg.per_en && (sec_evt || (half_evt && !cfg.rate_1hz));
        set        = hit_alarm || hit_period;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   status <= 1'b0;
        else if (set) status <= 1'b1;
        else if (clr) status <= 1'b0;
    end

    assign irq_req = status && (cfg.al_en || cfg.per_en);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int FINE_PPB      = 954,
    parameter int COARSE_PPB    = 3815
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          osc_tick,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    irq_cfg_t [ALARMS-1:0]   cfg_q;
    logic [ALARMS-1:0][31:0] cmp_q;
    logic [15:0]             corr_q;
    logic [7:0]              test_q;
    logic [31:0]             time_q, time_next;
    logic [ALARMS-1:0]       status_q, stat_clr, irq_req;
    logic time_wr, corr_wr, sec_evt, half_evt, counting, run;

    assign run       = (test_q == 8'h00);
    assign time_next = time_q + 32'd1;

    rtc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .time_q(time_q), .status_q(status_q),
        .cfg_q(cfg_q), .cmp_q(cmp_q), .corr_q(corr_q), .test_q(test_q),
        .time_wr(time_wr), .corr_wr(corr_wr), .stat_clr(stat_clr),
        .bus_rdata(bus_rdata)
    );

    rtc_sec_fsm #(
        .TICKS_PER_SEC(TICKS_PER_SEC), .FINE_PPB(FINE_PPB), .COARSE_PPB(COARSE_PPB)
    ) u_sec (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run(run),
        .restart(time_wr), .corr_clr(corr_wr), .corr(corr_q),
        .sec_evt(sec_evt), .half_evt(half_evt), .counting(counting)
    );

    for (genvar i = 0; i < ALARMS; i++) begin : g_alarm
        rtc_alarm_unit u_al (
            .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .half_evt(half_evt),
            .time_next(time_next), .cmp(cmp_q[i]), .cfg(cfg_q[i]),
            .clr(stat_clr[i]), .status(status_q[i]), .irq_req(irq_req[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       time_q <= '0;
        else if (time_wr) time_q <= bus_wdata;
        else if (sec_evt) time_q <= time_next;
    end

    assign irq = |irq_req;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        irq,
    input logic [31:0] time_q,
    input logic [1:0]  status_q,
    input logic        sec_evt,
    input logic        half_evt,
    input logic        counting,
    input logic        time_wr,
    input logic        al_en0,
    input logic [31:0] cmp0
);
    AST_HALT_HOLDS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !time_wr) |=> $stable(time_q)); // R2

    AST_SECOND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_evt |=> (time_q == $past(time_q) + 32'd1)); // R3

    AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_evt && al_en0 && (time_q + 32'd1 == cmp0)) |=> status_q[0]); // R5

    AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'h00 && bus_wdata[0] && !sec_evt && !half_evt)
        |=> !status_q[0]); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == 2'b00) |-> !irq); // R7
endmodule

bind rtc_core rtc_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .time_q(time_q), .status_q(status_q),
    .sec_evt(sec_evt), .half_evt(half_evt), .counting(counting),
    .time_wr(time_wr), .al_en0(cfg_q[0].al_en), .cmp0(cmp_q[0])
);

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
    localparam int TPS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_core #(.TICKS_PER_SEC(TPS)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    typedef struct packed {
        logic [4:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    // R4 write/readback table
    localparam vec_t VEC [6] = '{
        '{5'h10, 32'hDEADBEEF, 32'hDEADBEEF},
        '{5'h14, 32'h12345678, 32'h12345678},
        '{5'h04, 32'hFFFFFFFF, 32'h00000007},
        '{5'h08, 32'hFFFFFFF8, 32'h00000000},
        '{5'h18, 32'hFFFFABCD, 32'h0000ABCD},
        '{5'h1C, 32'h00000133, 32'h00000033}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); osc_tick = 1'b1;
            @(negedge clk); osc_tick = 1'b0;
        end
    endtask

    task automatic expect_reg(input string tag, input logic [4:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, e);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg("R1 time", 5'h0C, 32'h0);
        expect_reg("R1 status", 5'h00, 32'h0);
        expect_reg("R1 cfg0", 5'h04, 32'h0);
        expect_reg("R1 cfg1", 5'h08, 32'h0);
        expect_reg("R1 cmp1", 5'h14, 32'h0);
        expect_reg("R1 corr", 5'h18, 32'h2000);
        expect_reg("R1 test", 5'h1C, 32'hA5);
        check("R1 irq", 32'(irq), 32'h0);

        // R2 halted while configuration byte non-zero
        tick(40);
        expect_reg("R2 halted", 5'h0C, 32'h0);

        // R4 register widths
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i].a, VEC[i].w);
            expect_reg("R4 readback", VEC[i].a, VEC[i].e);
        end
        wr(5'h04, 0); wr(5'h10, 0); wr(5'h14, 0); wr(5'h18, 32'h2000);
        expect_reg("R2 still halted", 5'h0C, 32'h0);

        // R2 start
        wr(5'h1C, 0);
        tick(TPS - 1);
        expect_reg("R2 before first second", 5'h0C, 32'h0);
        tick(1);
        expect_reg("R2 first second", 5'h0C, 32'h1);

        // R3 wrap and restart
        wr(5'h0C, 32'hFFFFFFFF);
        expect_reg("R3 load", 5'h0C, 32'hFFFFFFFF);
        tick(TPS);
        expect_reg("R3 wrap", 5'h0C, 32'h0);
        tick(5);
        wr(5'h0C, 32'd10);
        tick(TPS - 1);
        expect_reg("R3 restart holds", 5'h0C, 32'd10);
        tick(1);
        expect_reg("R3 restart step", 5'h0C, 32'd11);

        // R5 alarm match, R7 irq
        wr(5'h10, 32'd13); wr(5'h04, 32'h1);
        wr(5'h14, 32'd13); wr(5'h08, 32'h0);
        wr(5'h0C, 32'd12);
        tick(TPS - 1);
        expect_reg("R5 no early fire", 5'h00, 32'h0);
        tick(1);
        expect_reg("R5 alarm0 fired, alarm1 disabled", 5'h00, 32'h1);
        check("R7 irq on", 32'(irq), 32'h1);
        // R6 write-one-to-clear
        wr(5'h00, 32'h2);
        expect_reg("R6 zero bit no effect", 5'h00, 32'h1);
        wr(5'h00, 32'h1);
        expect_reg("R6 cleared", 5'h00, 32'h0);
        check("R7 irq off", 32'(irq), 32'h0);
        // R7 masking by configuration
        wr(5'h0C, 32'd12);
        tick(TPS);
        wr(5'h04, 32'h0);
        expect_reg("R7 status kept", 5'h00, 32'h1);
        check("R7 irq masked", 32'(irq), 32'h0);
        wr(5'h00, 32'h3);

        // R8 periodic events
        wr(5'h08, 32'h2);
        wr(5'h0C, 32'd0);
        tick(TPS / 2 - 1);
        expect_reg("R8 before half", 5'h00, 32'h0);
        tick(1);
        expect_reg("R8 half event", 5'h00, 32'h2);
        check("R8 irq", 32'(irq), 32'h1);
        wr(5'h00, 32'h2);
        wr(5'h08, 32'h6);
        wr(5'h0C, 32'd0);
        tick(TPS / 2);
        expect_reg("R8 1Hz no half", 5'h00, 32'h0);
        tick(TPS / 2);
        expect_reg("R8 1Hz second", 5'h00, 32'h2);
        wr(5'h08, 32'h0);
        wr(5'h00, 32'h3);

        // R9 positive coarse +127: slip after second 129
        wr(5'h18, 32'hA07F);
        wr(5'h0C, 32'd0);
        tick(129 * TPS);
        expect_reg("R9 nominal run", 5'h0C, 32'd129);
        tick(TPS);
        expect_reg("R9 stretched second", 5'h0C, 32'd129);
        tick(1);
        expect_reg("R9 stretch end", 5'h0C, 32'd130);

        // R10 negative coarse -128: short second 129
        wr(5'h18, 32'h9F80);
        wr(5'h0C, 32'd0);
        tick(128 * TPS);
        expect_reg("R10 nominal run", 5'h0C, 32'd128);
        tick(TPS - 2);
        expect_reg("R10 before short end", 5'h0C, 32'd128);
        tick(1);
        expect_reg("R10 short second", 5'h0C, 32'd129);

        // R11 fine +127: slip after second 516
        wr(5'h18, 32'h207F);
        wr(5'h0C, 32'd0);
        tick(516 * TPS);
        expect_reg("R11 fine step run", 5'h0C, 32'd516);
        tick(TPS);
        expect_reg("R11 fine stretched", 5'h0C, 32'd516);
        tick(1);
        expect_reg("R11 fine stretch end", 5'h0C, 32'd517);

        // R12 invalid sign pattern gives nominal timing
        wr(5'h18, 32'hE07F);
        wr(5'h0C, 32'd0);
        tick(130 * TPS);
        expect_reg("R12 bad pattern nominal", 5'h0C, 32'd130);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule